// File: doc/BRIEF.md
# Bit-Level Pipelined Multiply-Accumulate Unit

This block computes one output of a serial FIR filter at a time. A coefficient and a delayed sample enter together on each clock. Their product is built in an unsigned array multiplier that has a register after every row of cells, so each cell only has to settle in one clock. Both operands travel down the array with their partial sums. Each finished product goes into an accumulator that stays in carry-save form, so the accumulator's feedback loop is only two full-adder levels deep. The coefficient store and the sample delay line are outside this block and feed it.

A marker on the final pair of a set closes the set. The carry-save total then goes through a column of registered half-adder rows, one row per accumulator bit, where a carry moves at most one bit position per row. At the bottom the result appears together with a one-cycle valid. The accumulator clears in the same cycle, so the next set can start on the following clock. Sums wrap modulo 2^ACC_W. The accumulator width defaults to 6 bits for 4×4 operands and to 12 bits for 8×8 operands.

Top module: `bitpipe_mac`

## Requirements
- R1: For every set, `res_o` equals the sum of `coef_i*samp_i` over the valid pairs of that set, taken modulo 2^ACC_W. A set runs from the pair after the previous last pair, or from reset, up to and including the pair with `last_i`=1.
- R2: The result appears with `res_valid_o`=1 after exactly W+ACC_W+1 rising edges, counted from and including the edge that captures the last pair.
- R3: `res_valid_o` is high for exactly one cycle for each captured pair with `last_i`=1, and is low at all other times.
- R4: A cycle with `in_valid_i`=0 leaves the accumulated sum unchanged.
- R5: A new set may begin on the cycle right after a last pair. It starts from zero and includes nothing from the previous set.
- R6: A set made of a single pair returns that pair's product.
- R7: With all operand bits set, the products and the sum wrap modulo 2^ACC_W and do not saturate.
- R8: While `rst_ni` is low, `res_valid_o` and `res_o` are 0. Reset discards any partial sum and any result still in flight.
- R9: `last_i` has no effect when `in_valid_i`=0.
- R10: The unit accepts one pair on every clock, with no stall between pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present this cycle |
| coef_i | input | W | Unsigned coefficient |
| samp_i | input | W | Unsigned delayed sample |
| last_i | input | 1 | Marks the final pair of a set |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | ACC_W | Accumulated sum modulo 2^ACC_W |

## Verification
The bench runs sets with no gap between them and sets of a single pair. A design that failed to clear the accumulator would carry the previous total into the next result. A design that cleared it a cycle late would drop the first product of the next set. Idle cycles are placed inside sets, some with `last_i` held high. A design that let `last_i` act without a valid pair would split the set and produce an extra strobe. A design that added the stale array contents would corrupt the sum. Operands with every bit set expose any missing carry row or a wrong modulus. A reset in the middle of a set catches partial sums or in-flight results that survive it. The reference model checks valid and value on every clock, so an off-by-one latency fails immediately.

// File: rtl/bitpipe_mac_pkg.sv
package bitpipe_mac_pkg;
  typedef struct packed {
    logic vld;
    logic lst;
  } tag_t;
endpackage

// File: rtl/bitpipe_mac_array.sv
module bitpipe_mac_array
  import bitpipe_mac_pkg::*;
#(
  parameter int W     = 4,
  parameter int ACC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tag_t             tag_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output tag_t             tag_o,
  output logic [ACC_W-1:0] sum_o,
  output logic [ACC_W-1:0] cry_o
);
  localparam int XW = ACC_W + W;

  for (genvar r = 0; r < W; r++) begin : g_row
    logic [W-1:0]     a_in, b_in, a_q, b_q;
    logic [ACC_W-1:0] s_in, c_in, pp, maj, s_q, c_q;
    logic [XW-1:0]    ext;
    tag_t             t_in, t_q;

    if (r == 0) begin : g_top
      assign a_in = a_i;
      assign b_in = b_i;
      assign s_in = '0;
      assign c_in = '0;
      assign t_in = '{vld: tag_i.vld, lst: tag_i.lst & tag_i.vld};
    end else begin : g_mid
      assign a_in = g_row[r-1].a_q;
      assign b_in = g_row[r-1].b_q;
      assign s_in = g_row[r-1].s_q;
      assign c_in = g_row[r-1].c_q;
      assign t_in = g_row[r-1].t_q;
    end

    // partial product row r, weight 2^r, truncated to accumulator width
    assign ext = XW'(a_in) << r;
    assign pp  = b_in[r] ? ext[ACC_W-1:0] : '0;
    assign maj = (s_in & c_in) | (s_in & pp) | (c_in & pp);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
        s_q <= '0;
        c_q <= '0;
        t_q <= '0;
      end else begin
        a_q <= a_in;
        b_q <= b_in;
        s_q <= s_in ^ c_in ^ pp;
        c_q <= {maj[ACC_W-2:0], 1'b0};
        t_q <= t_in;
      end
    end
  end

  assign tag_o = g_row[W-1].t_q;
  assign sum_o = g_row[W-1].s_q;
  assign cry_o = g_row[W-1].c_q;
endmodule

// File: rtl/bitpipe_mac_acc.sv
module bitpipe_mac_acc
  import bitpipe_mac_pkg::*;
#(
  parameter int ACC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tag_t             tag_i,
  input  logic [ACC_W-1:0] ps_i,
  input  logic [ACC_W-1:0] pc_i,
  output logic             v_o,
  output logic [ACC_W-1:0] s_o,
  output logic [ACC_W-1:0] c_o
);
  logic [ACC_W-1:0] acc_s_q, acc_c_q;
  logic [ACC_W-1:0] t_s, t_m, t_c, u_s, u_m, u_c;

  // 4:2 compression: two full-adder levels in the feedback loop
  assign t_s = acc_s_q ^ acc_c_q ^ ps_i;
  assign t_m = (acc_s_q & acc_c_q) | (acc_s_q & ps_i) | (acc_c_q & ps_i);
  assign t_c = {t_m[ACC_W-2:0], 1'b0};
  assign u_s = t_s ^ t_c ^ pc_i;
  assign u_m = (t_s & t_c) | (t_s & pc_i) | (t_c & pc_i);
  assign u_c = {u_m[ACC_W-2:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_s_q <= '0;
      acc_c_q <= '0;
      v_o     <= 1'b0;
      s_o     <= '0;
      c_o     <= '0;
    end else begin
      v_o <= tag_i.vld & tag_i.lst;
      if (tag_i.vld && tag_i.lst) begin
        s_o     <= u_s;
        c_o     <= u_c;
        acc_s_q <= '0;
        acc_c_q <= '0;
      end else if (tag_i.vld) begin
        acc_s_q <= u_s;
        acc_c_q <= u_c;
      end
    end
  end

  // R5
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (acc_s_q == '0) && (acc_c_q == '0));

  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_i.vld |=> $stable(acc_s_q) && $stable(acc_c_q));
endmodule

// File: rtl/bitpipe_mac_resolve.sv
module bitpipe_mac_resolve #(
  parameter int ACC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [ACC_W-1:0] s_i,
  input  logic [ACC_W-1:0] c_i,
  output logic             v_o,
  output logic [ACC_W-1:0] s_o
);
  // one half-adder row per bit: any carry clears within ACC_W rows
  for (genvar r = 0; r < ACC_W; r++) begin : g_row
    logic             v_in, v_q;
    logic [ACC_W-1:0] s_in, c_in, h, s_q, c_q;

    if (r == 0) begin : g_top
      assign v_in = v_i;
      assign s_in = s_i;
      assign c_in = c_i;
    end else begin : g_mid
      assign v_in = g_row[r-1].v_q;
      assign s_in = g_row[r-1].s_q;
      assign c_in = g_row[r-1].c_q;
    end

    assign h = s_in & c_in;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        s_q <= '0;
        c_q <= '0;
      end else begin
        v_q <= v_in;
        s_q <= s_in ^ c_in;
        c_q <= {h[ACC_W-2:0], 1'b0};
      end
    end
  end

  assign v_o = g_row[ACC_W-1].v_q;
  assign s_o = g_row[ACC_W-1].s_q;

  // R1
  carry_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_row[ACC_W-1].v_q |-> (g_row[ACC_W-1].c_q == '0));
endmodule

// File: rtl/bitpipe_mac.sv
module bitpipe_mac
  import bitpipe_mac_pkg::*;
#(
  parameter int W     = 4,
  parameter int ACC_W = W + W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [W-1:0]     coef_i,
  input  logic [W-1:0]     samp_i,
  input  logic             last_i,
  output logic             res_valid_o,
  output logic [ACC_W-1:0] res_o
);
  localparam int LAT = W + ACC_W + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  tag_t             arr_tag;
  logic [ACC_W-1:0] arr_s, arr_c, acc_s, acc_c;
  logic             acc_v;

  bitpipe_mac_array #(.W(W), .ACC_W(ACC_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  ('{vld: in_valid_i, lst: last_i}),
    .a_i    (coef_i),
    .b_i    (samp_i),
    .tag_o  (arr_tag),
    .sum_o  (arr_s),
    .cry_o  (arr_c)
  );

  bitpipe_mac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (arr_tag),
    .ps_i   (arr_s),
    .pc_i   (arr_c),
    .v_o    (acc_v),
    .s_o    (acc_s),
    .c_o    (acc_c)
  );

  bitpipe_mac_resolve #(.ACC_W(ACC_W)) u_resolve (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (acc_v),
    .s_i    (acc_s),
    .c_i    (acc_c),
    .v_o    (res_valid_o),
    .s_o    (res_o)
  );

  // results owed: closed sets not yet presented
  logic [CW-1:0] owed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else owed_q <= owed_q + CW'(in_valid_i & last_i) - CW'(res_valid_o);
  end

  // R3
  no_spurious_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (owed_q != '0));
endmodule

// File: tb/bitpipe_mac_bench.sv
module bitpipe_mac_bench;
  localparam int W     = 4;
  localparam int ACC_W = 6;
  localparam int LAT   = W + ACC_W + 1;
  localparam int MASK  = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [W-1:0]     coef = '0;
  logic [W-1:0]     samp = '0;
  logic             last = 1'b0;
  logic             res_valid;
  logic [ACC_W-1:0] res;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_en  = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bitpipe_mac #(.W(W), .ACC_W(ACC_W)) u_bitpipe_mac (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .coef_i      (coef),
    .samp_i      (samp),
    .last_i      (last),
    .res_valid_o (res_valid),
    .res_o       (res)
  );

  // reference: running sum plus a delay line of expected results
  int ref_acc;
  bit exp_v [LAT];
  int exp_d [LAT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_acc = 0;
      for (int i = 0; i < LAT; i++) begin
        exp_v[i] <= 1'b0;
        exp_d[i] <= 0;
      end
    end else begin
      for (int i = 1; i < LAT; i++) begin
        exp_v[i] <= exp_v[i-1];
        exp_d[i] <= exp_d[i-1];
      end
      exp_v[0] <= 1'b0;
      if (in_valid) begin
        ref_acc = (ref_acc + int'(coef) * int'(samp)) & MASK;
        if (last) begin
          exp_v[0] <= 1'b1;
          exp_d[0] <= ref_acc;
          ref_acc = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      n_tests++;
      if (res_valid !== exp_v[LAT-1]) begin
        n_fail++;
        $display("FAIL %s R2/R3 res_valid_o=%0b expected %0b", cur_req, res_valid, exp_v[LAT-1]);
      end else if (res_valid && (int'(res) != exp_d[LAT-1])) begin
        n_fail++;
        $display("FAIL %s R1 res_o=%0d expected %0d", cur_req, res, exp_d[LAT-1]);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      last     = 1'b0;
      coef     = '0;
      samp     = '0;
    end
  endtask

  // mode 0 random, 1 all ones; gaps inserts idle cycles with last held high
  task automatic send_set(int n, int mode, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        last     = 1'b1;          // R9: must be ignored
        coef     = W'($urandom);
        samp     = W'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b1;
      coef     = (mode == 1) ? '1 : W'($urandom);
      samp     = (mode == 1) ? '1 : W'($urandom);
      last     = (i == n - 1);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    n_tests++;
    if (res_valid !== 1'b0 || res !== '0) begin
      n_fail++;
      $display("FAIL R8 reset res_valid_o=%0b res_o=%0d expected 0 0", res_valid, res);
    end
    rst_n  = 1'b1;
    chk_en = 1'b1;
    idle(2);

    cur_req = "R6";
    for (int k = 0; k < 4; k++) send_set(1, 0, 1'b0);
    idle(LAT + 2);

    cur_req = "R5+R10";
    for (int k = 0; k < 12; k++) send_set($urandom_range(1, 6), 0, 1'b0);
    idle(LAT + 2);

    cur_req = "R7";
    send_set(1, 1, 1'b0);
    send_set(5, 1, 1'b0);
    send_set(16, 1, 1'b0);
    idle(LAT + 2);

    cur_req = "R4+R9";
    for (int k = 0; k < 20; k++) send_set($urandom_range(1, 8), 0, 1'b1);
    idle(LAT + 2);

    cur_req = "R1";
    for (int k = 0; k < 60; k++) begin
      send_set($urandom_range(1, 10), $urandom_range(0, 4) == 0 ? 1 : 0, 1'b0);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(LAT + 2);

    // R8: reset mid-set and with results in flight
    cur_req = "R8";
    send_set(3, 0, 1'b0);
    send_set(4, 0, 1'b0);
    idle(2);
    @(negedge clk);
    in_valid = 1'b1;
    coef     = '1;
    samp     = '1;
    last     = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    n_tests++;
    if (res_valid !== 1'b0 || res !== '0) begin
      n_fail++;
      $display("FAIL R8 in reset res_valid_o=%0b res_o=%0d expected 0 0", res_valid, res);
    end
    @(negedge clk);
    rst_n = 1'b1;
    send_set(2, 0, 1'b0);
    idle(LAT + 2);
    for (int k = 0; k < 8; k++) send_set($urandom_range(1, 5), 0, 1'b1);
    idle(LAT + 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule